// File: doc/BRIEF.md
# Planar Video Pixel Fetch Unit

This block turns a horizontal pixel position into a 4-bit attribute index. It reads bytes from a display memory that is split into four parallel planes of bytes. A request carries an X coordinate, a row start address, a 2-bit shift-mode selector and a pixel-divide amount. The X coordinate is shifted right by the divide amount before any address arithmetic is done.

The block reaches memory through a single byte-wide read port. The port has a plane select and an offset, and it returns data exactly one cycle after the read strobe. Each shift mode maps memory to pixels in its own way:

- Planar mode takes one bit from each of the four planes, so it issues four reads.
- Interleaved mode takes one 2-bit field from each of two planes, so it issues two reads.
- Nibble mode takes half of one byte, so it issues a single read.

The block drops its ready output while the remaining reads of a pixel are still being issued. In nibble mode it accepts a new pixel every cycle. Each pixel appears on the output with a one-cycle valid strobe, a fixed number of cycles after it was accepted.

Top module: `pix_fetch`

## Requirements
- R1: After reset, `pix_valid` is low and `req_ready` is high.
- R2: Every address, plane and bit selection uses xd = `req_x` >> `div_shift`, and never the raw X coordinate.
- R3: Mode encoding: `shift_mode` 0 is planar, 1 is interleaved, and 2 and 3 both select nibble mode with identical results.
- R4: Planar mode: the offset is xd/8 + `row_base`, and the bit taken from each byte is bit (7 − xd mod 8). The output takes bit 3 from plane 3, bit 2 from plane 2, bit 1 from plane 1 and bit 0 from plane 0.
- R5: Planar mode reads planes 0, 1, 2 and 3 on four consecutive cycles, all at the same offset. `req_ready` is low for the three cycles after acceptance.
- R6: Interleaved mode: the base plane is bit 2 of xd and the offset is xd/8 + `row_base`. The block reads the base plane first, then plane (base | 2) on the next cycle, and `req_ready` is low for the one cycle between the two reads.
- R7: Interleaved mode: each read supplies the 2-bit field at bits [7−2s : 6−2s], where s = xd mod 4. Output bits 1:0 come from the base plane and bits 3:2 come from plane (base | 2).
- R8: Nibble mode: the plane is bits 2:1 of xd and the offset is xd/8 + `row_base`. An even xd selects byte bits 7:4 and an odd xd selects bits 3:0. Only one read is issued, so `req_ready` stays high and a request can be accepted every cycle.
- R9: A pixel whose request is accepted at clock edge k appears with `pix_valid` high for exactly one cycle, after edge k + n. Here n is the number of reads for its mode: 4, 2 or 1. Pixels come out in request order.
- R10: The offset sum wraps modulo 2^OW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pixel request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_x | input | XW | Pixel X coordinate |
| row_base | input | OW | Row start address |
| shift_mode | input | 2 | Plane-to-pixel mapping selector |
| div_shift | input | DSW | Right shift applied to X |
| mem_rd | output | 1 | Memory read strobe |
| mem_plane | output | 2 | Plane select for the read |
| mem_offs | output | OW | Byte offset for the read |
| mem_data | input | 8 | Read data, valid one cycle after `mem_rd` |
| pix_valid | output | 1 | Pixel result strobe |
| pix_value | output | 4 | Attribute index |

## Verification
A pixel accepted at edge k is due after edge k+4 in planar mode, k+2 in interleaved mode and k+1 in nibble mode. The `req_ready` output must be low for n−1 cycles after each acceptance.

The bench records the acceptance edge of every request, together with its due edge and its expected value, in an ordered queue. It compares `pix_valid` and `pix_value` on falling edges against the head of that queue, so any early, late or missing pixel is reported. On every falling edge it also checks `req_ready` against a countdown of the reads still to be issued.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    MODE_PLANAR = 2'd0,
    MODE_INTLV  = 2'd1,
    MODE_NIB    = 2'd2,
    MODE_NIB_B  = 2'd3
  } shmode_t;

  // context carried alongside a memory read until its data returns
  typedef struct packed {
    logic       last;
    logic [1:0] step;
    logic [1:0] mode;
    logic [2:0] sel;
  } rdtag_t;

  // index of the final read step for a mode
  function automatic logic [1:0] last_step(input logic [1:0] mode);
    case (mode)
      MODE_PLANAR: last_step = 2'd3;
      MODE_INTLV:  last_step = 2'd1;
      default:     last_step = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] plane_of(input logic [1:0] mode,
                                          input logic [1:0] step,
                                          input logic [2:0] sel);
    case (mode)
      MODE_PLANAR: plane_of = step;
      MODE_INTLV:  plane_of = {step[0], sel[2]};
      default:     plane_of = sel[2:1];
    endcase
  endfunction
endpackage

// File: rtl/pf_addr.sv
module pf_addr #(
  parameter int XW  = 10,
  parameter int OW  = 16,
  parameter int DSW = 2
) (
  input  logic [XW-1:0]  x_in,
  input  logic [OW-1:0]  row_in,
  input  logic [DSW-1:0] div_in,
  output logic [OW-1:0]  offs_out,
  output logic [2:0]     sel_out
);
  logic [XW-1:0] xd;
  logic [XW-1:0] col;

  always_comb begin
    xd       = x_in >> div_in;
    col      = xd >> 3;
    offs_out = OW'(col) + row_in;
    sel_out  = xd[2:0];
  end
endmodule

// File: rtl/pf_seq.sv
module pf_seq
  import pf_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    mode_in,
  input  logic [2:0]    sel_in,
  input  logic [OW-1:0] offs_in,
  output logic          req_ready,
  output logic          mem_rd,
  output logic [1:0]    mem_plane,
  output logic [OW-1:0] mem_offs,
  output rdtag_t        tag_out
);
  logic          busy_q, busy_d;
  logic [1:0]    step_q, step_d;
  logic [1:0]    mode_q;
  logic [2:0]    sel_q;
  logic [OW-1:0] offs_q;
  logic          ctx_en;
  logic [1:0]    cur_mode, cur_step;
  logic [2:0]    cur_sel;
  logic          is_last;

  always_comb begin
    req_ready = !busy_q;
    ctx_en    = !busy_q && req_valid;
    cur_mode  = busy_q ? mode_q : mode_in;
    cur_sel   = busy_q ? sel_q  : sel_in;
    cur_step  = busy_q ? step_q : 2'd0;
    mem_offs  = busy_q ? offs_q : offs_in;
    mem_rd    = busy_q || req_valid;
    mem_plane = plane_of(cur_mode, cur_step, cur_sel);
    is_last   = (cur_step == last_step(cur_mode));
    busy_d    = mem_rd && !is_last;
    step_d    = cur_step + 2'd1;
    tag_out   = '{last: is_last, step: cur_step, mode: cur_mode, sel: cur_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
      offs_q <= '0;
    end else if (ctx_en) begin
      mode_q <= mode_in;
      sel_q  <= sel_in;
      offs_q <= offs_in;
    end
  end

  // R5
  planar_second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_in == MODE_PLANAR)
      |=> (mem_rd && mem_plane == 2'd1 && !req_ready));
  // R6
  intlv_high_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_in == MODE_INTLV)
      |=> (mem_rd && mem_plane[1] && !req_ready));
  // R8
  nib_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_in[1]) |=> req_ready);
  // R6
  offs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $stable(mem_offs));
endmodule

// File: rtl/pf_collect.sv
module pf_collect
  import pf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_in,
  input  rdtag_t     tag_in,
  input  logic [7:0] mem_data,
  output logic       pix_valid,
  output logic [3:0] pix_value
);
  logic       tagv_q;
  rdtag_t     tag_q;
  logic [2:0] acc_q, acc_d;
  logic       acc_en;
  logic [3:0] pix_d;
  logic       bit_s;
  logic [1:0] fld;
  logic [3:0] nib;

  always_comb begin
    bit_s = mem_data[3'd7 - tag_q.sel];
    case (tag_q.sel[1:0])
      2'd0:    fld = mem_data[7:6];
      2'd1:    fld = mem_data[5:4];
      2'd2:    fld = mem_data[3:2];
      default: fld = mem_data[1:0];
    endcase
    nib    = tag_q.sel[0] ? mem_data[3:0] : mem_data[7:4];
    acc_d  = acc_q;
    pix_d  = pix_value;
    acc_en = tagv_q && !tag_q.last;
    case (tag_q.mode)
      MODE_PLANAR: begin
        acc_d[tag_q.step] = bit_s;
        pix_d = {bit_s, acc_q};
      end
      MODE_INTLV: begin
        acc_d[1:0] = fld;
        pix_d = {fld, acc_q[1:0]};
      end
      default: pix_d = nib;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagv_q    <= 1'b0;
      pix_valid <= 1'b0;
    end else begin
      tagv_q    <= rd_in;
      pix_valid <= tagv_q && tag_q.last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= '0;
      acc_q     <= '0;
      pix_value <= '0;
    end else begin
      if (rd_in) tag_q <= tag_in;
      if (acc_en) acc_q <= acc_d;
      if (tagv_q && tag_q.last) pix_value <= pix_d;
    end
  end

  // R9
  pix_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && tag_in.last) |=> ##1 pix_valid);
  // R9
  pix_single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tagv_q && tag_q.last) |=> !pix_valid);
  // R5
  planar_step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tagv_q && tag_q.mode == MODE_PLANAR && !tag_q.last)
      |-> (rd_in && tag_in.step == tag_q.step + 2'd1));
endmodule

// File: rtl/pix_fetch.sv
module pix_fetch
  import pf_pkg::*;
#(
  parameter int XW  = 10,
  parameter int OW  = 16,
  parameter int DSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [XW-1:0]  req_x,
  input  logic [OW-1:0]  row_base,
  input  logic [1:0]     shift_mode,
  input  logic [DSW-1:0] div_shift,
  output logic           mem_rd,
  output logic [1:0]     mem_plane,
  output logic [OW-1:0]  mem_offs,
  input  logic [7:0]     mem_data,
  output logic           pix_valid,
  output logic [3:0]     pix_value
);
  logic [OW-1:0] a_offs;
  logic [2:0]    a_sel;
  rdtag_t        rd_tag;

  pf_addr #(.XW(XW), .OW(OW), .DSW(DSW)) u_addr (
    .x_in     (req_x),
    .row_in   (row_base),
    .div_in   (div_shift),
    .offs_out (a_offs),
    .sel_out  (a_sel)
  );

  pf_seq #(.OW(OW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode_in   (shift_mode),
    .sel_in    (a_sel),
    .offs_in   (a_offs),
    .req_ready (req_ready),
    .mem_rd    (mem_rd),
    .mem_plane (mem_plane),
    .mem_offs  (mem_offs),
    .tag_out   (rd_tag)
  );

  pf_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_in     (mem_rd),
    .tag_in    (rd_tag),
    .mem_data  (mem_data),
    .pix_valid (pix_valid),
    .pix_value (pix_value)
  );

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !pix_valid));
endmodule

// File: tb/pix_fetch_bench.sv
module pix_fetch_bench;
  localparam int XW = 10, OW = 16, DSW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, req_valid, req_ready, mem_rd, pix_valid;
  logic [XW-1:0]  req_x;
  logic [OW-1:0]  row_base, mem_offs;
  logic [1:0]     shift_mode, mem_plane;
  logic [DSW-1:0] div_shift;
  logic [7:0]     mem_data;
  logic [3:0]     pix_value;

  pix_fetch #(.XW(XW), .OW(OW), .DSW(DSW)) u_pix_fetch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .row_base(row_base), .shift_mode(shift_mode),
    .div_shift(div_shift), .mem_rd(mem_rd), .mem_plane(mem_plane),
    .mem_offs(mem_offs), .mem_data(mem_data), .pix_valid(pix_valid),
    .pix_value(pix_value)
  );

  int total = 0, bad = 0, cyc = 0, left = 0;
  int    due_q[$];
  logic [3:0] val_q[$];
  string req_q[$];
  string lreq = "R5";

  function automatic logic [7:0] memf(logic [1:0] p, logic [15:0] o);
    return (o[7:0] * 8'd29) ^ (o[15:8] * 8'd7) ^ ({6'd0, p} * 8'd85) ^ 8'h3c;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_data <= memf(mem_plane, mem_offs);
  end

  function automatic int nrd(logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  function automatic string rq(logic [1:0] m);
    return (m == 2'd0) ? "R4" : (m == 2'd1) ? "R7" : "R8";
  endfunction

  function automatic logic [3:0] expv(logic [9:0] x, logic [15:0] row,
                                      logic [1:0] m, logic [1:0] dv);
    logic [9:0] xd;
    logic [15:0] off;
    logic [7:0] b0, b1;
    logic [3:0] r;
    int sh;
    xd  = x >> dv;
    off = 16'(xd >> 3) + row;
    if (m == 2'd0) begin
      for (int p = 0; p < 4; p++) r[p] = memf(2'(p), off)[7 - int'(xd[2:0])];
    end else if (m == 2'd1) begin
      sh = 6 - 2 * int'(xd[1:0]);
      b0 = memf({1'b0, xd[2]}, off) >> sh;
      b1 = memf({1'b1, xd[2]}, off) >> sh;
      r  = {b1[1:0], b0[1:0]};
    end else begin
      b0 = memf(xd[2:1], off);
      r  = xd[0] ? b0[3:0] : b0[7:4];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", r, act, exp, cyc);
    end
  endtask

  // monitor: pixel timing and value (R9, R4, R7, R8), ready pattern (R5, R6, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) begin
        if (due_q.size() == 0) chk(0, "R9", 1, 0);
        else begin
          chk(cyc == due_q[0], "R9", cyc, due_q[0]);
          chk(pix_value == val_q[0], req_q[0], pix_value, val_q[0]);
          void'(due_q.pop_front()); void'(val_q.pop_front()); void'(req_q.pop_front());
        end
      end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
        chk(0, "R9", cyc, due_q[0]);
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(req_q.pop_front());
      end
      chk(req_ready == (left == 0), lreq, req_ready, left == 0);
      if (left > 0) left--;
      if (req_valid && req_ready) begin
        due_q.push_back(cyc + 1 + nrd(shift_mode));
        val_q.push_back(expv(req_x, row_base, shift_mode, div_shift));
        req_q.push_back(rq(shift_mode));
        left = nrd(shift_mode) - 1;
        lreq = (shift_mode == 2'd0) ? "R5" : (shift_mode == 2'd1) ? "R6" : "R8";
      end
    end
  end

  task automatic send(logic [9:0] x, logic [15:0] row, logic [1:0] m, logic [1:0] dv);
    @(posedge clk); #1;
    req_x = x; row_base = row; shift_mode = m; div_shift = dv; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_x = '0; row_base = '0;
    shift_mode = '0; div_shift = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1", pix_valid, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    // R4 planar leftmost and rightmost pixel of a byte
    send(10'd0, 16'h0100, 2'd0, 2'd0);
    send(10'd7, 16'h0100, 2'd0, 2'd0);
    // R6 R7 interleaved, second base plane, last field
    send(10'd4, 16'h0020, 2'd1, 2'd0);
    send(10'd3, 16'h0020, 2'd1, 2'd0);
    // R8 nibble odd/even, R3 mode 3 equals mode 2
    send(10'd1, 16'h0040, 2'd2, 2'd0);
    send(10'd1, 16'h0040, 2'd3, 2'd0);
    send(10'd6, 16'h0040, 2'd3, 2'd0);
    // R2 divide: x=0x25 >> 2 = 9
    send(10'h25, 16'h0300, 2'd0, 2'd2);
    send(10'h25, 16'h0300, 2'd1, 2'd1);
    // R10 offset wrap
    send(10'd40, 16'hFFFF, 2'd2, 2'd0);
    idle();
    // R8 back-to-back nibble burst
    for (int i = 0; i < 16; i++) send(10'(i * 3), 16'h0500, 2'd2, 2'd0);
    idle();
    repeat (4) @(posedge clk);
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 == 0) idle();
      send(10'($urandom), 16'($urandom), 2'($urandom), 2'($urandom));
    end
    idle();
    repeat (10) @(posedge clk);
    chk(due_q.size() == 0, "R9", due_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule